// File: doc/BRIEF.md
# Prescaled I2C Clock Rate Generator

This block produces the serial clock timing for an I2C bus master from the system clock. Software sets an 8-bit rate value and a 2-bit prescaler code. Together they give a clock period of 16 + 2·BR·P system clocks, where P is the multiplier that the code selects. The period is split into a low phase and a high phase of equal nominal length, 8 + BR·P clocks each. The block drives a clock-release output and gives the byte engine single-cycle strobes. These strobes mark the start and end of each phase, the point where SDA may change (mid low phase) and the point where SDA should be sampled (mid high phase).

The generator reads back the sampled bus clock. Once it has released the line, it does not start timing the high phase until the line reads high. A target that holds the clock low therefore lengthens the period and does not eat into the high time. New rate or prescaler values are taken only at a period boundary. When the enable input is low, the clock is released and all timing state is cleared.

Top module: `sclgen_top`

## Requirements
- R1: While `en` is low (and after reset), `scl_o` is 1 (released) and all four strobes are 0. One cycle after `en` is seen low, this holds even in the middle of a period.
- R2: One cycle after `en` is first seen high with the block idle, `scl_o` goes to 0 and `ph_start` is 1. The low phase lasts exactly 8 + BR·P cycles.
- R3: Prescaler code `ps` selects the multiplier P as 2'b00 → 1, 2'b01 → 4, 2'b10 → 16 and 2'b11 → 64.
- R4: When the line is not stretched, the period from one low-phase start to the next is 16 + 2·BR·P cycles. For example, BR = 72 with code 00 gives 160 cycles.
- R5: The high phase counts 8 + BR·P cycles, starting at the first cycle in which `scl_in` reads 1 after release. Cycles in which a target holds `scl_in` at 0 add to the period.
- R6: Values of `br` and `ps` are captured only when a new low phase begins. A change made during a period does not alter that period.
- R7: `ph_start` is 1 on the first cycle of each low phase and on the first counted cycle of each high phase. `ph_end` is 1 on the last cycle of each phase.
- R8: Number the cycles of a phase from 0. `sda_chg` is 1 on low-phase cycle floor(H/2) and `sda_smp` is 1 on counted high-phase cycle floor(H/2), where H = 8 + BR·P.
- R9: BR = 0 gives a 16-cycle period for every prescaler code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low releases the clock and clears timing |
| br | input | 8 | Bit-rate value BR |
| ps | input | 2 | Prescaler code |
| scl_in | input | 1 | Synchronised level of the bus clock line |
| scl_o | output | 1 | 1 = release clock line, 0 = pull it low |
| ph_start | output | 1 | First cycle of a phase |
| ph_end | output | 1 | Last cycle of a phase |
| sda_chg | output | 1 | Point at which SDA may change (mid low phase) |
| sda_smp | output | 1 | Point at which SDA should be sampled (mid high phase) |

## Verification
On every cycle, the embedded assertions check several local rules. The clock is released one cycle after the enable drops, and an idle block pulls low on enable. The high-phase counter stays frozen while a target holds the line low, and the captured phase length does not move except at a boundary. No strobe lands in the wrong phase. The exact period and phase lengths for each prescaler code, the 160-cycle case, the zero-rate case, the deferral of a mid-period rate change and the stretched high phase can only be shown by the bench. It drives those scenarios against a behavioural model that is compared on every clock.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    parameter int BR_W = 8;
    parameter int PS_W = 2;
    localparam int NUM_PS    = 1 << PS_W;
    localparam int SHIFT_MAX = 2 * (NUM_PS - 1);
    localparam int CNT_W     = BR_W + SHIFT_MAX + 1;
    localparam int BASE_HALF = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic start;
        logic fin;
        logic sda_chg;
        logic sda_smp;
    } strobe_t;

    // Half-period length for one prescaler position: 8 + br * 4^idx
    function automatic cnt_t half_for(input logic [BR_W-1:0] br_v, input int idx);
        return cnt_t'(BASE_HALF) + (cnt_t'(br_v) << (2 * idx));
    endfunction

endpackage

// File: rtl/sclgen_rate_latch.sv
module sclgen_rate_latch
    import sclgen_pkg::*;
#(
    parameter int RB_W = BR_W,
    parameter int RP_W = PS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [RB_W-1:0] br,
    input  logic [RP_W-1:0] ps,
    output cnt_t            half_q
);
    localparam int N_SEL = 1 << RP_W;

    cnt_t cand [N_SEL];

    // One candidate half length per prescaler code
    genvar g;
    generate
        for (g = 0; g < N_SEL; g++) begin : g_cand
            assign cand[g] = half_for(br, g);
        end
    endgenerate

    // Capture only at a period boundary (R6)
    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= cnt_t'(BASE_HALF);
        end else if (load) begin
            half_q <= cand[ps];
        end
    end

endmodule

// File: rtl/sclgen_phase_ctrl.sv
module sclgen_phase_ctrl
    import sclgen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    scl_in,
    input  cnt_t    half,
    output logic    load,
    output logic    scl_o,
    output strobe_t strb
);
    phase_e st;
    cnt_t   cnt;
    logic   counting;
    logic   last;
    cnt_t   mid;

    always_comb begin
        mid      = half >> 1;
        counting = (st == PH_LOW) || ((st == PH_HIGH) && ((cnt != '0) || scl_in));
        last     = counting && (cnt == half - cnt_t'(1));
        load     = en && (((st == PH_IDLE)) || ((st == PH_HIGH) && last));
        scl_o    = (st != PH_LOW);
        strb.start   = ((st == PH_LOW) && (cnt == '0)) ||
                       ((st == PH_HIGH) && (cnt == '0) && scl_in);
        strb.fin     = last;
        strb.sda_chg = (st == PH_LOW) && (cnt == mid);
        strb.sda_smp = (st == PH_HIGH) && (cnt == mid);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st  <= PH_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                PH_IDLE: begin
                    st  <= PH_LOW;
                    cnt <= '0;
                end
                PH_LOW: begin
                    if (last) begin
                        st  <= PH_HIGH;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + cnt_t'(1);
                    end
                end
                PH_HIGH: begin
                    if (last) begin
                        st  <= PH_LOW;
                        cnt <= '0;
                    end else if (counting) begin
                        cnt <= cnt + cnt_t'(1);
                    end
                end
                default: begin
                    st  <= PH_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    // R1: disabled generator releases the line and stays silent
    a_r1_disabled_released: assert property (@(posedge clk) disable iff (rst)
        !en |=> (scl_o && !strb.start && !strb.fin && !strb.sda_chg && !strb.sda_smp));

    // R2: an idle block pulls the line low one cycle after enable
    a_r2_enable_pulls_low: assert property (@(posedge clk) disable iff (rst)
        ((st == PH_IDLE) && en) |=> (!scl_o && strb.start));

    // R5: high-phase timing frozen while the line is held low
    a_r5_wait_for_line: assert property (@(posedge clk) disable iff (rst)
        ((st == PH_HIGH) && (cnt == '0) && !scl_in && en) |=> ((st == PH_HIGH) && (cnt == '0)));

    // R6: captured length moves only on a load
    a_r6_half_frozen: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(half));

    // R7: a phase never starts and ends in the same cycle
    a_r7_start_not_end: assert property (@(posedge clk) disable iff (rst)
        !(strb.start && strb.fin));

    // R8: data-change point inside low phase, sample point with the line high
    a_r8_chg_in_low: assert property (@(posedge clk) disable iff (rst)
        strb.sda_chg |-> !scl_o);
    a_r8_smp_line_high: assert property (@(posedge clk) disable iff (rst)
        strb.sda_smp |-> (scl_o && scl_in));

endmodule

// File: rtl/sclgen_top.sv
module sclgen_top
    import sclgen_pkg::*;
#(
    parameter int TOP_BR_W = BR_W,
    parameter int TOP_PS_W = PS_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [TOP_BR_W-1:0] br,
    input  logic [TOP_PS_W-1:0] ps,
    input  logic                scl_in,
    output logic                scl_o,
    output logic                ph_start,
    output logic                ph_end,
    output logic                sda_chg,
    output logic                sda_smp
);
    logic    load;
    cnt_t    half;
    strobe_t strb;

    sclgen_rate_latch #(
        .RB_W (TOP_BR_W),
        .RP_W (TOP_PS_W)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .br     (br),
        .ps     (ps),
        .half_q (half)
    );

    sclgen_phase_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .scl_in (scl_in),
        .half   (half),
        .load   (load),
        .scl_o  (scl_o),
        .strb   (strb)
    );

    assign ph_start = strb.start;
    assign ph_end   = strb.fin;
    assign sda_chg  = strb.sda_chg;
    assign sda_smp  = strb.sda_smp;

endmodule

// File: tb/sclgen_top_test.sv
`timescale 1ns/1ps
module sclgen_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] br  = 8'd0;
    logic [1:0] ps  = 2'd0;
    logic       scl_in;
    logic       scl_o, ph_start, ph_end, sda_chg, sda_smp;

    // Target stretching model
    logic       stretch_req = 1'b0;
    logic       hold = 1'b0;
    int         hold_cnt = 0;
    int         stretch_len = 5;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    assign scl_in = scl_o & ~hold;

    sclgen_top uut (
        .clk(clk), .rst(rst), .en(en), .br(br), .ps(ps), .scl_in(scl_in),
        .scl_o(scl_o), .ph_start(ph_start), .ph_end(ph_end),
        .sda_chg(sda_chg), .sda_smp(sda_smp)
    );

    always @(posedge clk) begin
        if (!stretch_req) begin
            hold     <= 1'b0;
            hold_cnt <= 0;
        end else if (!scl_o) begin
            hold     <= 1'b1;
            hold_cnt <= 0;
        end else if (hold) begin
            if (hold_cnt == stretch_len - 1) hold <= 1'b0;
            hold_cnt <= hold_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_ph    = 0;   // 0 idle, 1 low, 2 high
    int  m_idx   = 0;
    int  m_half  = 8;
    bit  m_valid = 0;

    function automatic int half_of(input int b, input int p);
        return 8 + b * (1 << (2 * p));
    endfunction

    always @(negedge clk) begin
        if (m_valid) begin
            bit e_scl, e_start, e_end, e_chg, e_smp, cnt_on;
            cnt_on  = (m_ph == 1) || (m_ph == 2 && (m_idx != 0 || scl_in));
            e_scl   = (m_ph != 1);
            e_start = (m_ph == 1 && m_idx == 0) || (m_ph == 2 && m_idx == 0 && scl_in);
            e_end   = cnt_on && (m_idx == m_half - 1);
            e_chg   = (m_ph == 1) && (m_idx == m_half / 2);
            e_smp   = (m_ph == 2) && (m_idx == m_half / 2);
            check(scl_o == e_scl, "R2 model scl_o", int'(scl_o), int'(e_scl));
            check(ph_start == e_start, "R7 model ph_start", int'(ph_start), int'(e_start));
            check(ph_end == e_end, "R7 model ph_end", int'(ph_end), int'(e_end));
            check(sda_chg == e_chg, "R8 model sda_chg", int'(sda_chg), int'(e_chg));
            check(sda_smp == e_smp, "R8 model sda_smp", int'(sda_smp), int'(e_smp));
        end
        if (rst || !en) begin
            m_ph  = 0;
            m_idx = 0;
            if (rst) m_valid = 1;
        end else if (m_ph == 0) begin
            m_ph = 1; m_idx = 0; m_half = half_of(int'(br), int'(ps));
        end else if (m_ph == 1) begin
            if (m_idx == m_half - 1) begin m_ph = 2; m_idx = 0; end
            else m_idx++;
        end else begin
            if (m_idx == 0 && !scl_in) begin
                // line held low: wait
            end else if (m_idx == m_half - 1) begin
                m_ph = 1; m_idx = 0; m_half = half_of(int'(br), int'(ps));
            end else m_idx++;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- directed scenarios ----------------
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_low_start();
        do step(); while (!(ph_start && !scl_o));
    endtask

    task automatic measure(output int n, output int hi);
        wait_low_start();
        n = 0; hi = 0;
        do begin
            step();
            n++;
            if (scl_in) hi++;
        end while (!(ph_start && !scl_o));
    endtask

    initial begin
        int n, hi, n2, hi2;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: reset / disabled state
        check(scl_o == 1'b1, "R1 idle scl_o", int'(scl_o), 1);
        check({ph_start, ph_end, sda_chg, sda_smp} == 4'b0, "R1 idle strobes",
              int'({ph_start, ph_end, sda_chg, sda_smp}), 0);

        // R2: enable pulls low next cycle
        br = 8'd72; ps = 2'd0; en = 1'b1;
        step();
        check(scl_o == 1'b0 && ph_start, "R2 low after enable", int'(scl_o), 0);

        // R4: 160-cycle period, equal halves
        measure(n, hi);
        check(n == 160, "R4 period br72 x1", n, 160);
        check(hi == 80, "R5 high time br72 x1", hi, 80);

        // R3: prescaler codes
        for (int p = 0; p < 4; p++) begin
            ps = 2'(p); br = 8'd3;
            measure(n, hi);
            check(n == 16 + 6 * (1 << (2 * p)), "R3 period per prescaler code", n,
                  16 + 6 * (1 << (2 * p)));
        end

        // R9: zero rate
        br = 8'd0; ps = 2'd3;
        measure(n, hi);
        check(n == 16, "R9 zero rate x64", n, 16);
        ps = 2'd0;
        measure(n, hi);
        check(n == 16, "R9 zero rate x1", n, 16);

        // R6: mid-period change deferred to the boundary
        br = 8'd10;
        measure(n, hi);
        check(n == 36, "R6 base period", n, 36);
        // measure() ends on a low-phase start: change now, mid period
        br = 8'd20;
        n2 = 0;
        do begin step(); n2++; end while (!(ph_start && !scl_o));
        check(n2 == 36, "R6 period during change", n2, 36);
        n2 = 0;
        do begin step(); n2++; end while (!(ph_start && !scl_o));
        check(n2 == 56, "R6 period after change", n2, 56);

        // R5: stretching lengthens the period, high time intact
        br = 8'd10;
        measure(n, hi);
        stretch_req = 1'b1;
        measure(n2, hi2);
        measure(n2, hi2);
        check(hi2 == 18, "R5 stretched high time", hi2, 18);
        check(n2 > 36, "R5 stretched period longer", n2, 37);
        stretch_req = 1'b0;
        measure(n, hi);
        measure(n, hi);
        check(n == 36, "R5 period after stretch", n, 36);

        // R1: disable mid-period
        step(); step();
        en = 1'b0;
        step();
        check(scl_o == 1'b1, "R1 disabled mid period scl_o", int'(scl_o), 1);
        check(!ph_start && !ph_end && !sda_chg && !sda_smp, "R1 disabled strobes",
              int'({ph_start, ph_end, sda_chg, sda_smp}), 0);
        repeat (4) step();
        en = 1'b1; br = 8'd1; ps = 2'd1;
        step();
        check(!scl_o && ph_start, "R2 restart low", int'(scl_o), 0);
        measure(n, hi);
        check(n == 24, "R3 restart period code 01", n, 24);

        repeat (3) step();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule